// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block lets a CPU with a 16-bit address bus reach more memory than its bus can name directly. The lower 48K of the CPU address space is a window; a small selection register decides which of four 64K-aligned physical banks is seen through that window. Bank 0 is the native bank. Banks 1, 2 and 3 each add 48K of extra storage. The upper 16K of the CPU space always reaches the native bank, so the total reachable storage is 64K + 3 x 48K = 212,992 bytes.

The selection register is written out of band, through an I/O write to a single port address. The CPU can read the same port back. Memory cycles pass through the mapper combinationally: it adds two upper address bits to the CPU address to form an 18-bit physical address, and it raises a chip select while a memory read or write strobe is active.

Top module: `bank_mapper`

## Requirements
- R1: After a synchronous reset the selected bank is 0, so every CPU address maps to physical address {2'b00, cpu_addr}.
- R2: A CPU address below 0xC000 maps to physical address {bank, cpu_addr}, where bank is the current 2-bit selection.
- R3: A CPU address from 0xC000 to 0xFFFF maps to {2'b00, cpu_addr}, whatever bank is selected.
- R4: An I/O write to port 0x40 with a data value 0 to 3 loads that value as the bank. The new bank applies from the cycle after the write edge. During the write cycle itself the old bank still applies.
- R5: An I/O write to port 0x40 with a data value above 3 is ignored, and the bank keeps its previous value.
- R6: An I/O write to any port other than 0x40 leaves the bank unchanged.
- R7: While io_rd is high and io_addr is 0x40, io_rdata is the bank in bits [1:0] with zeros above them. Otherwise io_rdata is 0.
- R8: mem_cs is high exactly when mem_rd or mem_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | CPU memory read strobe |
| mem_wr | input | 1 | CPU memory write strobe |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (bank readback) |
| phys_addr | output | 18 | Physical memory address |
| mem_cs | output | 1 | Memory chip select |

## Verification
The address translation, the chip select and the readback are combinational, so the bench checks them in the same cycle as the stimulus, one time step after it drives the inputs on the falling edge. A bank write lands on the next rising edge. The bench therefore compares against its model bank from before that edge while the write strobe is still high, and updates the model only after the edge. This keeps the one-cycle delay of R4 visible, and a mapper that used the new bank too early would be caught.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
    localparam int CPU_AW    = 16;
    localparam int BANK_W    = 2;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int PHYS_AW   = CPU_AW + BANK_W;
    localparam int IO_AW     = 8;
    localparam int IO_DW     = 8;

    // First CPU address above the banked window (window is 0x0000..0xBFFF)
    localparam logic [CPU_AW-1:0] WIN_END = 16'hC000;

    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        bank_t             bank;
        logic [CPU_AW-1:0] offs;
    } phys_t;

    function automatic logic bank_ok(input logic [IO_DW-1:0] v);
        return 32'(v) < NUM_BANKS;
    endfunction

    function automatic logic in_window(input logic [CPU_AW-1:0] a);
        return a < WIN_END;
    endfunction
endpackage

// File: rtl/bank_select_reg.sv
module bank_select_reg
    import bank_map_pkg::*;
#(
    parameter logic [IO_AW-1:0] SEL_PORT = 8'h40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [IO_DW-1:0] io_wdata,
    output logic [IO_DW-1:0] io_rdata,
    output bank_t            bank_o
);
    bank_t bank_q;
    logic  port_hit;
    logic  load_ok;

    assign port_hit = (io_addr == SEL_PORT);
    assign load_ok  = io_wr && port_hit && bank_ok(io_wdata);

    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= '0;
        else if (load_ok)
            bank_q <= io_wdata[BANK_W-1:0];
    end

    assign bank_o   = bank_q;
    assign io_rdata = (io_rd && port_hit) ? {{(IO_DW-BANK_W){1'b0}}, bank_q} : '0;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (bank_q == '0));

    assert_load_value_R4: assert property (@(posedge clk) disable iff (rst)
        (io_wr && port_hit && (io_wdata < IO_DW'(NUM_BANKS)))
            |=> (bank_q == $past(io_wdata[BANK_W-1:0])));

    assert_ignore_big_R5: assert property (@(posedge clk) disable iff (rst)
        (io_wr && port_hit && (io_wdata >= IO_DW'(NUM_BANKS))) |=> $stable(bank_q));

    assert_other_port_R6: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !port_hit) |=> $stable(bank_q));
endmodule

// File: rtl/window_decode.sv
module window_decode
    import bank_map_pkg::*;
(
    input  logic [CPU_AW-1:0] cpu_addr,
    input  bank_t             bank,
    output phys_t             phys
);
    always_comb begin
        phys.offs = cpu_addr;
        phys.bank = in_window(cpu_addr) ? bank : bank_t'(0);
    end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_map_pkg::*;
#(
    parameter logic [IO_AW-1:0] SEL_PORT = 8'h40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic               mem_rd,
    input  logic               mem_wr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [IO_AW-1:0]   io_addr,
    input  logic [IO_DW-1:0]   io_wdata,
    output logic [IO_DW-1:0]   io_rdata,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic               mem_cs
);
    bank_t cur_bank;
    phys_t phys;

    bank_select_reg #(.SEL_PORT(SEL_PORT)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .bank_o   (cur_bank)
    );

    window_decode u_win (
        .cpu_addr (cpu_addr),
        .bank     (cur_bank),
        .phys     (phys)
    );

    assign phys_addr = phys;
    assign mem_cs    = mem_rd | mem_wr;

    assert_top_native_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr >= WIN_END) |-> (phys_addr[PHYS_AW-1:CPU_AW] == '0));

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (rst)
        phys_addr[CPU_AW-1:0] == cpu_addr);
endmodule

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic        mem_rd, mem_wr, io_wr, io_rd;
    logic [7:0]  io_addr, io_wdata, io_rdata;
    logic [17:0] phys_addr;
    logic        mem_cs;

    int vectors = 0;
    int errors  = 0;
    logic [1:0] mbank;

    always #5 clk = ~clk;

    bank_mapper uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .phys_addr(phys_addr), .mem_cs(mem_cs)
    );

    function automatic logic [17:0] exp_phys(input logic [1:0] b, input logic [15:0] a);
        return (a < 16'hC000) ? {b, a} : {2'b00, a};
    endfunction

    function automatic logic [7:0] exp_rdata(input logic rd, input logic [7:0] pa, input logic [1:0] b);
        return (rd && pa == 8'h40) ? {6'b0, b} : 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive on falling edge, check 1 ns later, then let the rising edge commit.
    task automatic cycle(input logic [15:0] a, input logic rd, input logic wr,
                         input logic iw, input logic ir, input logic [7:0] pa,
                         input logic [7:0] d, input string req);
        @(negedge clk);
        cpu_addr = a; mem_rd = rd; mem_wr = wr;
        io_wr = iw; io_rd = ir; io_addr = pa; io_wdata = d;
        #1;
        chk({req, " phys"}, 32'(phys_addr), 32'(exp_phys(mbank, a)));
        chk("R8 cs", 32'(mem_cs), 32'(rd | wr));
        chk("R7 rdata", 32'(io_rdata), 32'(exp_rdata(ir, pa, mbank)));
        @(posedge clk);
        if (iw && pa == 8'h40 && d < 8'd4) mbank = d[1:0];
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; cpu_addr = '0; mem_rd = 0; mem_wr = 0;
        io_wr = 0; io_rd = 0; io_addr = '0; io_wdata = '0;
        mbank = 2'd0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        cycle(16'h1234, 1, 0, 0, 1, 8'h40, 8'h00, "R1");
        // R4: write bank 2; old bank still applies in the write cycle
        cycle(16'h0100, 1, 0, 1, 0, 8'h40, 8'h02, "R4 same-cycle");
        cycle(16'h0100, 1, 0, 0, 1, 8'h40, 8'h00, "R4 next-cycle");
        chk("R4 bank", 32'(phys_addr[17:16]), 32'd2);
        // R2/R3 boundaries
        cycle(16'hBFFF, 0, 1, 0, 0, 8'h00, 8'h00, "R2 window top");
        chk("R2 edge", 32'(phys_addr), 32'h2BFFF);
        cycle(16'hC000, 0, 1, 0, 0, 8'h00, 8'h00, "R3 native bottom");
        chk("R3 edge", 32'(phys_addr), 32'h0C000);
        cycle(16'hFFFF, 1, 0, 0, 0, 8'h00, 8'h00, "R3 native top");
        // R5: value above 3 ignored
        cycle(16'h0000, 0, 0, 1, 0, 8'h40, 8'h05, "R5 write");
        cycle(16'h0000, 1, 0, 0, 1, 8'h40, 8'h00, "R5 after");
        chk("R5 bank held", 32'(io_rdata), 32'd2);
        // R6: other port ignored
        cycle(16'h0000, 0, 0, 1, 0, 8'h41, 8'h01, "R6 write");
        cycle(16'h0000, 1, 0, 0, 1, 8'h40, 8'h00, "R6 after");
        chk("R6 bank held", 32'(io_rdata), 32'd2);
        // R7: readback at another port is zero
        cycle(16'h0000, 0, 0, 0, 1, 8'h3F, 8'h00, "R7 other port");
        // bank 3 and back to native
        cycle(16'h8000, 0, 0, 1, 0, 8'h40, 8'h03, "R4 to 3");
        cycle(16'h8000, 1, 0, 0, 0, 8'h00, 8'h00, "R2 bank3");
        chk("R2 bank3", 32'(phys_addr), 32'h38000);

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a  = 16'($urandom);
            logic [7:0]  pa = ($urandom_range(0, 3) != 0) ? 8'h40 : 8'($urandom);
            logic [7:0]  d  = ($urandom_range(0, 3) != 0) ? 8'($urandom_range(0, 3)) : 8'($urandom);
            cycle(a, 1'($urandom), 1'($urandom), ($urandom_range(0, 2) == 0),
                  1'($urandom), pa, d, "R2/R3 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule